// File: doc/BRIEF.md
# Region-Tagged Address Translator with Key-Based Protection

This block maps a 64-bit virtual address to a physical address. The three top address bits pick one of eight region registers, and the 24-bit region ID held there forms the tag of the search. A fully associative array of translation entries is then searched on the pair of region ID and virtual page number. Each entry has its own page size: 4 KB, 64 KB, 16 MB or 4 GB. A hit supplies a physical page number, a three-bit rights field and a protection key. The key is then matched against a bank of key registers. The rights of the matching key register are ANDed with the entry's rights before the requested access is checked.

Software-side loaders write the region registers, the key registers and the entries through plain write strobes. An entry write either names its slot directly or takes the slot under a round-robin victim pointer. Lookups use a valid/ready handshake. A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the result register is empty, or when its content is taken in the same cycle (`res_ready` high). A result that is not taken stays unchanged and blocks new requests. A lookup always sees the table state from before any write in the same cycle.

Top module: `xlat_unit`

## Requirements
- R1: Bits 63:61 of the request address select a region register, and the region ID stored there must equal an entry's region ID for that entry to match. The address bits themselves never act as the region tag.
- R2: An entry matches when it is valid, its region ID is equal, and every virtual page number bit at address position 12 or above that also lies at or above the entry's offset width is equal. The size codes are 0=4 KB (12 offset bits), 1=64 KB (16), 2=16 MB (24) and 3=4 GB (32).
- R3: On a fault-free lookup, physical address bits below the matched entry's offset width come from the virtual address, and the bits above come from the entry's page number (page number bit k is address bit k+12). On any fault the physical address is zero.
- R4: The matched entry's key is compared against all valid key registers, and the lowest-index match supplies the key rights. If no valid register matches, the result is a key-miss fault.
- R5: The effective rights are the entry rights ANDed with the key rights: bit0 read, bit1 write, bit2 execute. Access code 0 needs read, 1 needs write and 2 needs execute. Code 3 always faults on rights. A missing right gives a rights fault.
- R6: The fault code is 0 for none, 1 for entry miss, 2 for key miss and 3 for rights. Only one code is reported, with priority entry miss, then key miss, then rights. `res_hit` is high exactly when an entry matched.
- R7: When several entries match, the lowest-index entry supplies the result and `res_multi` is high. Otherwise `res_multi` is low.
- R8: An entry write with `fill_ovr` high goes to `fill_idx`. Otherwise it goes to the victim slot, which starts at 0 after reset, advances by one only on such writes, and wraps after the last slot.
- R9: A result appears on the clock edge after acceptance. While `res_valid` is high and `res_ready` is low, the result holds steady and `req_ready` is low.
- R10: Reset invalidates every entry and every key register, sets the region IDs to zero and the victim slot to 0, and empties the result register. The first lookup after reset reports an entry miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rgn_we | input | 1 | Region register write strobe |
| rgn_idx | input | 3 | Region register to write |
| rgn_rid | input | 24 | Region ID to store |
| key_we | input | 1 | Key register write strobe |
| key_idx | input | 3 | Key register to write |
| key_valid | input | 1 | Valid bit to store |
| key_val | input | 24 | Key value to store |
| key_rights | input | 3 | Key rights to store (bit0 r, bit1 w, bit2 x) |
| fill_we | input | 1 | Entry write strobe |
| fill_ovr | input | 1 | Use fill_idx instead of the victim slot |
| fill_idx | input | 4 | Explicit entry slot |
| fill_valid | input | 1 | Entry valid bit to store |
| fill_rid | input | 24 | Entry region ID |
| fill_vpn | input | 49 | Entry virtual page number (address bits 60:12) |
| fill_size | input | 2 | Entry page size code |
| fill_ppn | input | 40 | Entry physical page number (address bits 51:12) |
| fill_rights | input | 3 | Entry rights (bit0 r, bit1 w, bit2 x) |
| fill_key | input | 24 | Entry protection key |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be taken |
| req_va | input | 64 | Virtual address |
| req_acc | input | 2 | Access code |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result taken by consumer |
| res_pa | output | 52 | Physical address |
| res_hit | output | 1 | An entry matched |
| res_multi | output | 1 | More than one entry matched |
| res_fault | output | 2 | Fault code |

## Verification
The bench targets page sizes whose offset width swallows bits of the virtual page number. A design that compares those bits would miss on 64 KB, 16 MB and 4 GB pages, and one that takes them from the entry would corrupt the physical address. Overlapping large and small entries force multiple hits, where picking the wrong entry would show as a wrong address or a missing flag. Keys duplicated across key registers expose wrong priority as a spurious rights fault. A stalled consumer combined with a waiting request exposes a design that drops or overwrites an untaken result. Mixed override and round-robin fills show up as missing or stale hits if the victim pointer moves on the wrong writes.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    FLT_NONE     = 2'd0,
    FLT_TLB_MISS = 2'd1,
    FLT_KEY_MISS = 2'd2,
    FLT_RIGHTS   = 2'd3
  } xl_fault_e;

  localparam int unsigned BASE_OFF = 12;

  // offset width in address bits for each page size code
  function automatic int unsigned off_bits(input logic [1:0] sz);
    case (sz)
      2'd0:    return 12;
      2'd1:    return 16;
      2'd2:    return 24;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/xlat_rgn_file.sv
module xlat_rgn_file #(
  parameter  int N_RGN = 8,
  parameter  int RID_W = 24,
  localparam int IDX_W = $clog2(N_RGN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [RID_W-1:0] wrid,
  input  logic [IDX_W-1:0] ridx,
  output logic [RID_W-1:0] rrid
);

  logic [RID_W-1:0] rid_q [N_RGN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_RGN; i++) rid_q[i] <= '0;
    end else if (we) begin
      rid_q[widx] <= wrid;
    end
  end

  assign rrid = rid_q[ridx];

endmodule

// File: rtl/xlat_key_file.sv
module xlat_key_file #(
  parameter  int N_KEY = 8,
  parameter  int KEY_W = 24,
  localparam int IDX_W = $clog2(N_KEY)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic             wvalid,
  input  logic [KEY_W-1:0] wkey,
  input  logic [2:0]       wrights,
  input  logic [KEY_W-1:0] key,
  output logic             hit,
  output logic [2:0]       rights
);

  logic             kv_q [N_KEY];
  logic [KEY_W-1:0] kk_q [N_KEY];
  logic [2:0]       kr_q [N_KEY];
  logic [N_KEY-1:0] kmatch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_KEY; i++) kv_q[i] <= 1'b0;
    end else if (we) begin
      kv_q[widx] <= wvalid;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      kk_q[widx] <= wkey;
      kr_q[widx] <= wrights;
    end
  end

  for (genvar g = 0; g < N_KEY; g++) begin : g_kcmp
    assign kmatch[g] = kv_q[g] && (kk_q[g] == key);
  end

  // scan from the top so the lowest matching index wins
  always_comb begin
    hit    = 1'b0;
    rights = '0;
    for (int i = N_KEY - 1; i >= 0; i--) begin
      if (kmatch[i]) begin
        hit    = 1'b1;
        rights = kr_q[i];
      end
    end
  end

  AST_KEY_NOHIT_NORIGHTS: assert property (@(posedge clk) disable iff (!rst_n)
    (kmatch == '0) |-> (!hit && rights == 3'b000)); // R4

endmodule

// File: rtl/xlat_tlb_array.sv
module xlat_tlb_array
  import xlat_pkg::*;
#(
  parameter  int N_ENT  = 16,
  parameter  int RID_W  = 24,
  parameter  int VPN_W  = 49,
  parameter  int PPN_W  = 40,
  parameter  int KEY_W  = 24,
  localparam int EIDX_W = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              ovr,
  input  logic [EIDX_W-1:0] idx,
  input  logic              wvalid,
  input  logic [RID_W-1:0]  wrid,
  input  logic [VPN_W-1:0]  wvpn,
  input  logic [1:0]        wsize,
  input  logic [PPN_W-1:0]  wppn,
  input  logic [2:0]        wrights,
  input  logic [KEY_W-1:0]  wkey,
  input  logic [RID_W-1:0]  rid,
  input  logic [VPN_W-1:0]  vpn,
  output logic              hit,
  output logic              multi,
  output logic [PPN_W-1:0]  ppn,
  output logic [1:0]        size,
  output logic [2:0]        rights,
  output logic [KEY_W-1:0]  key
);

  logic              e_valid  [N_ENT];
  logic [RID_W-1:0]  e_rid    [N_ENT];
  logic [VPN_W-1:0]  e_vpn    [N_ENT];
  logic [1:0]        e_size   [N_ENT];
  logic [PPN_W-1:0]  e_ppn    [N_ENT];
  logic [2:0]        e_rights [N_ENT];
  logic [KEY_W-1:0]  e_key    [N_ENT];

  logic [EIDX_W-1:0] vict;
  logic [EIDX_W-1:0] widx;
  logic [N_ENT-1:0]  match;
  logic [EIDX_W-1:0] sel;
  logic [EIDX_W:0]   nmatch;

  assign widx = ovr ? idx : vict;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) e_valid[i] <= 1'b0;
      vict <= '0;
    end else if (we) begin
      e_valid[widx] <= wvalid;
      if (!ovr) vict <= vict + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      e_rid[widx]    <= wrid;
      e_vpn[widx]    <= wvpn;
      e_size[widx]   <= wsize;
      e_ppn[widx]    <= wppn;
      e_rights[widx] <= wrights;
      e_key[widx]    <= wkey;
    end
  end

  // per-entry compare, page number bits inside the page offset are ignored
  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic [VPN_W-1:0] care;
    always_comb begin
      for (int b = 0; b < VPN_W; b++) begin
        care[b] = (b + int'(BASE_OFF)) >= int'(off_bits(e_size[g]));
      end
    end
    assign match[g] = e_valid[g] && (e_rid[g] == rid) &&
                      (((e_vpn[g] ^ vpn) & care) == '0);
  end

  always_comb begin
    hit    = 1'b0;
    sel    = '0;
    nmatch = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit = 1'b1;
        sel = EIDX_W'(i);
      end
    end
    for (int i = 0; i < N_ENT; i++) begin
      nmatch = nmatch + {{EIDX_W{1'b0}}, match[i]};
    end
  end

  assign multi  = (nmatch > 1);
  assign ppn    = e_ppn[sel];
  assign size   = e_size[sel];
  assign rights = e_rights[sel];
  assign key    = e_key[sel];

  AST_VICT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !ovr) |=> (vict == $past(vict) + 1'b1)); // R8
  AST_VICT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && !ovr) |=> $stable(vict)); // R8
  AST_SEL_IS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> match[sel]); // R7

endmodule

// File: rtl/xlat_unit.sv
module xlat_unit
  import xlat_pkg::*;
#(
  parameter  int VA_W     = 64,
  parameter  int PA_W     = 52,
  parameter  int RID_W    = 24,
  parameter  int KEY_W    = 24,
  parameter  int N_ENT    = 16,
  parameter  int N_KEY    = 8,
  localparam int RGN_BITS = 3,
  localparam int N_RGN    = 1 << RGN_BITS,
  localparam int VPN_W    = VA_W - RGN_BITS - 12,
  localparam int PPN_W    = PA_W - 12,
  localparam int EIDX_W   = $clog2(N_ENT),
  localparam int KIDX_W   = $clog2(N_KEY)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rgn_we,
  input  logic [RGN_BITS-1:0] rgn_idx,
  input  logic [RID_W-1:0]    rgn_rid,
  input  logic                key_we,
  input  logic [KIDX_W-1:0]   key_idx,
  input  logic                key_valid,
  input  logic [KEY_W-1:0]    key_val,
  input  logic [2:0]          key_rights,
  input  logic                fill_we,
  input  logic                fill_ovr,
  input  logic [EIDX_W-1:0]   fill_idx,
  input  logic                fill_valid,
  input  logic [RID_W-1:0]    fill_rid,
  input  logic [VPN_W-1:0]    fill_vpn,
  input  logic [1:0]          fill_size,
  input  logic [PPN_W-1:0]    fill_ppn,
  input  logic [2:0]          fill_rights,
  input  logic [KEY_W-1:0]    fill_key,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [VA_W-1:0]     req_va,
  input  logic [1:0]          req_acc,
  output logic                res_valid,
  input  logic                res_ready,
  output logic [PA_W-1:0]     res_pa,
  output logic                res_hit,
  output logic                res_multi,
  output logic [1:0]          res_fault
);

  logic [RID_W-1:0] cur_rid;
  logic             t_hit;
  logic             t_multi;
  logic [PPN_W-1:0] t_ppn;
  logic [1:0]       t_size;
  logic [2:0]       t_rights;
  logic [KEY_W-1:0] t_key;
  logic             k_hit;
  logic [2:0]       k_rights;
  logic [2:0]       eff;
  logic             allowed;
  xl_fault_e        fault_c;
  logic [PA_W-1:0]  pa_c;
  int unsigned      off_c;
  logic             accept;

  xlat_rgn_file #(.N_RGN(N_RGN), .RID_W(RID_W)) i_rgn (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (rgn_we),
    .widx (rgn_idx),
    .wrid (rgn_rid),
    .ridx (req_va[VA_W-1 -: RGN_BITS]),
    .rrid (cur_rid)
  );

  xlat_tlb_array #(
    .N_ENT(N_ENT), .RID_W(RID_W), .VPN_W(VPN_W), .PPN_W(PPN_W), .KEY_W(KEY_W)
  ) i_tlb (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (fill_we),
    .ovr    (fill_ovr),
    .idx    (fill_idx),
    .wvalid (fill_valid),
    .wrid   (fill_rid),
    .wvpn   (fill_vpn),
    .wsize  (fill_size),
    .wppn   (fill_ppn),
    .wrights(fill_rights),
    .wkey   (fill_key),
    .rid    (cur_rid),
    .vpn    (req_va[VA_W-RGN_BITS-1:12]),
    .hit    (t_hit),
    .multi  (t_multi),
    .ppn    (t_ppn),
    .size   (t_size),
    .rights (t_rights),
    .key    (t_key)
  );

  xlat_key_file #(.N_KEY(N_KEY), .KEY_W(KEY_W)) i_key (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (key_we),
    .widx   (key_idx),
    .wvalid (key_valid),
    .wkey   (key_val),
    .wrights(key_rights),
    .key    (t_key),
    .hit    (k_hit),
    .rights (k_rights)
  );

  assign eff = t_rights & k_rights;

  always_comb begin
    case (req_acc)
      2'd0:    allowed = eff[0];
      2'd1:    allowed = eff[1];
      2'd2:    allowed = eff[2];
      default: allowed = 1'b0;
    endcase
  end

  always_comb begin
    if (!t_hit)        fault_c = FLT_TLB_MISS;
    else if (!k_hit)   fault_c = FLT_KEY_MISS;
    else if (!allowed) fault_c = FLT_RIGHTS;
    else               fault_c = FLT_NONE;
  end

  assign off_c = off_bits(t_size);

  always_comb begin
    pa_c = '0;
    for (int j = 0; j < PA_W; j++) begin
      if (j < int'(off_c)) pa_c[j] = req_va[j];
      else                 pa_c[j] = t_ppn[j-12];
    end
  end

  assign req_ready = !res_valid || res_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_pa    <= '0;
      res_hit   <= 1'b0;
      res_multi <= 1'b0;
      res_fault <= FLT_NONE;
    end else if (accept) begin
      res_valid <= 1'b1;
      res_pa    <= (fault_c == FLT_NONE) ? pa_c : '0;
      res_hit   <= t_hit;
      res_multi <= t_multi;
      res_fault <= fault_c;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  AST_RESULT_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> res_valid); // R9
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_pa) &&
                                   $stable(res_fault) && $stable(res_hit))); // R9
  AST_HIT_AGREES_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_hit == (res_fault != FLT_TLB_MISS))); // R6
  AST_MULTI_IMPLIES_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_multi) |-> res_hit); // R7
  AST_PA_ZERO_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault != FLT_NONE) |-> (res_pa == '0)); // R3

endmodule

// File: tb/test_xlat_unit.sv
`timescale 1ns/1ps
module test_xlat_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rgn_we = 1'b0;
  logic [2:0]  rgn_idx = '0;
  logic [23:0] rgn_rid = '0;
  logic        key_we = 1'b0;
  logic [2:0]  key_idx = '0;
  logic        key_valid = 1'b0;
  logic [23:0] key_val = '0;
  logic [2:0]  key_rights = '0;
  logic        fill_we = 1'b0;
  logic        fill_ovr = 1'b0;
  logic [3:0]  fill_idx = '0;
  logic        fill_valid = 1'b0;
  logic [23:0] fill_rid = '0;
  logic [48:0] fill_vpn = '0;
  logic [1:0]  fill_size = '0;
  logic [39:0] fill_ppn = '0;
  logic [2:0]  fill_rights = '0;
  logic [23:0] fill_key = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_va = '0;
  logic [1:0]  req_acc = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [51:0] res_pa;
  logic        res_hit;
  logic        res_multi;
  logic [1:0]  res_fault;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  xlat_unit i_xlat_unit (
    .clk(clk), .rst_n(rst_n),
    .rgn_we(rgn_we), .rgn_idx(rgn_idx), .rgn_rid(rgn_rid),
    .key_we(key_we), .key_idx(key_idx), .key_valid(key_valid),
    .key_val(key_val), .key_rights(key_rights),
    .fill_we(fill_we), .fill_ovr(fill_ovr), .fill_idx(fill_idx),
    .fill_valid(fill_valid), .fill_rid(fill_rid), .fill_vpn(fill_vpn),
    .fill_size(fill_size), .fill_ppn(fill_ppn), .fill_rights(fill_rights),
    .fill_key(fill_key),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_acc(req_acc),
    .res_valid(res_valid), .res_ready(res_ready), .res_pa(res_pa),
    .res_hit(res_hit), .res_multi(res_multi), .res_fault(res_fault)
  );

  // reference state
  logic [23:0] m_rr   [8];
  logic        m_kv   [8];
  logic [23:0] m_kk   [8];
  logic [2:0]  m_kr   [8];
  logic        m_tv   [16];
  logic [23:0] m_trid [16];
  logic [48:0] m_tvpn [16];
  logic [1:0]  m_tsz  [16];
  logic [39:0] m_tppn [16];
  logic [2:0]  m_trt  [16];
  logic [23:0] m_tkey [16];
  int          m_vict;

  function automatic int offw(input logic [1:0] sz);
    case (sz) 2'd0: return 12; 2'd1: return 16; 2'd2: return 24; default: return 32; endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [63:0] va, input logic [1:0] acc,
                       output logic [51:0] pa, output logic hit, output logic multi,
                       output logic [1:0] flt);
    int e; int k; int cnt; int off;
    logic [23:0] rid; logic [63:0] ent; logic [63:0] vlow; logic [63:0] pm;
    logic [63:0] full; logic [2:0] r;
    e = -1; k = -1; cnt = 0;
    rid = m_rr[va[63:61]];
    vlow = va & 64'h1FFF_FFFF_FFFF_FFFF;
    for (int i = 0; i < 16; i++) begin
      off = offw(m_tsz[i]);
      ent = {3'b000, m_tvpn[i], 12'h000};
      if (m_tv[i] && m_trid[i] == rid && ((vlow >> off) == (ent >> off))) begin
        cnt++;
        if (e < 0) e = i;
      end
    end
    hit = (e >= 0);
    multi = (cnt > 1);
    pa = '0;
    if (e < 0) flt = 2'd1;
    else begin
      for (int i = 7; i >= 0; i--) if (m_kv[i] && m_kk[i] == m_tkey[e]) k = i;
      if (k < 0) flt = 2'd2;
      else begin
        r = m_trt[e] & m_kr[k];
        if (acc != 2'd3 && r[acc]) flt = 2'd0; else flt = 2'd3;
      end
      if (flt == 2'd0) begin
        pm = (64'd1 << offw(m_tsz[e])) - 64'd1;
        full = {12'h000, m_tppn[e], 12'h000};
        pa = 52'((full & ~pm) | (va & pm));
      end
    end
  endtask

  task automatic lookup(input logic [63:0] va, input logic [1:0] acc, input string req);
    logic [51:0] epa; logic eh; logic em; logic [1:0] ef;
    @(negedge clk);
    req_va = va; req_acc = acc; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    model(va, acc, epa, eh, em, ef);
    chk(req, "res_valid", 64'(res_valid), 64'd1);
    chk(req, "res_fault", 64'(res_fault), 64'(ef));
    chk(req, "res_hit", 64'(res_hit), 64'(eh));
    chk(req, "res_multi", 64'(res_multi), 64'(em));
    chk(req, "res_pa", 64'(res_pa), 64'(epa));
  endtask

  task automatic wr_rgn(input int i, input logic [23:0] rid);
    @(negedge clk);
    rgn_we = 1'b1; rgn_idx = 3'(i); rgn_rid = rid;
    @(negedge clk);
    rgn_we = 1'b0;
    m_rr[i] = rid;
  endtask

  task automatic wr_key(input int i, input logic v, input logic [23:0] kv, input logic [2:0] kr);
    @(negedge clk);
    key_we = 1'b1; key_idx = 3'(i); key_valid = v; key_val = kv; key_rights = kr;
    @(negedge clk);
    key_we = 1'b0;
    m_kv[i] = v; m_kk[i] = kv; m_kr[i] = kr;
  endtask

  task automatic wr_ent(input logic ovr, input int idx, input logic v, input logic [23:0] rid,
                        input logic [48:0] vpn, input logic [1:0] sz, input logic [39:0] ppn,
                        input logic [2:0] rt, input logic [23:0] key);
    int s;
    @(negedge clk);
    fill_we = 1'b1; fill_ovr = ovr; fill_idx = 4'(idx); fill_valid = v; fill_rid = rid;
    fill_vpn = vpn; fill_size = sz; fill_ppn = ppn; fill_rights = rt; fill_key = key;
    @(negedge clk);
    fill_we = 1'b0;
    if (ovr) s = idx; else begin s = m_vict; m_vict = (m_vict + 1) % 16; end
    m_tv[s] = v; m_trid[s] = rid; m_tvpn[s] = vpn; m_tsz[s] = sz;
    m_tppn[s] = ppn; m_trt[s] = rt; m_tkey[s] = key;
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] va;
    logic [51:0] epa; logic eh; logic em; logic [1:0] ef;
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) begin m_rr[i] = '0; m_kv[i] = 1'b0; m_kk[i] = '0; m_kr[i] = '0; end
    for (int i = 0; i < 16; i++) begin
      m_tv[i] = 1'b0; m_trid[i] = '0; m_tvpn[i] = '0; m_tsz[i] = '0;
      m_tppn[i] = '0; m_trt[i] = '0; m_tkey[i] = '0;
    end
    m_vict = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk("R10", "res_valid after reset", 64'(res_valid), 64'd0);
    chk("R10", "req_ready after reset", 64'(req_ready), 64'd1);
    lookup(64'h0, 2'd0, "R10");

    for (int i = 0; i < 8; i++) wr_rgn(i, 24'h100 + 24'(i % 4));
    wr_key(0, 1'b1, 24'd5, 3'b111);
    wr_key(2, 1'b1, 24'd7, 3'b001);
    wr_key(4, 1'b1, 24'd7, 3'b111);

    // R2/R3: one entry per page size, round-robin slots 0..3
    wr_ent(1'b0, 0, 1'b1, 24'h101, 49'h0_1234_5678, 2'd0, 40'hAB_CDEF_0123, 3'b111, 24'd5);
    wr_ent(1'b0, 0, 1'b1, 24'h101, 49'h0_2222_0000, 2'd1, 40'h11_2233_4455, 3'b111, 24'd5);
    wr_ent(1'b0, 0, 1'b1, 24'h102, 49'h0_3333_3000, 2'd2, 40'h66_7788_99AA, 3'b111, 24'd5);
    wr_ent(1'b0, 0, 1'b1, 24'h103, 49'h1_4400_0000, 2'd3, 40'hFE_DCBA_9876, 3'b111, 24'd5);
    lookup({3'd1, 49'h0_1234_5678, 12'hABC}, 2'd0, "R2");
    lookup({3'd1, 49'h0_2222_000F, 12'h123}, 2'd0, "R3");
    lookup({3'd2, 49'h0_3333_3FFF, 12'hFFF}, 2'd1, "R3");
    lookup({3'd3, 49'h1_440F_FFFF, 12'h777}, 2'd2, "R2");
    lookup({3'd1, 49'h0_1234_5679, 12'h000}, 2'd0, "R2");
    // R1: same page number through a region whose ID differs, then one that shares it
    lookup({3'd2, 49'h0_1234_5678, 12'hABC}, 2'd0, "R1");
    lookup({3'd5, 49'h0_1234_5678, 12'h010}, 2'd0, "R1");

    // R4: key miss, then key found; duplicate key picks lowest register
    wr_ent(1'b0, 0, 1'b1, 24'h100, 49'h0_0000_0042, 2'd0, 40'h00_0000_0042, 3'b111, 24'd9);
    lookup({3'd0, 49'h0_0000_0042, 12'h008}, 2'd0, "R4");
    wr_key(3, 1'b1, 24'd9, 3'b111);
    lookup({3'd0, 49'h0_0000_0042, 12'h008}, 2'd0, "R4");
    wr_ent(1'b1, 9, 1'b1, 24'h100, 49'h0_0000_0077, 2'd0, 40'h00_0000_0077, 3'b111, 24'd7);
    lookup({3'd4, 49'h0_0000_0077, 12'h000}, 2'd1, "R4");
    lookup({3'd4, 49'h0_0000_0077, 12'h000}, 2'd0, "R4");

    // R5: rights AND and access codes
    wr_ent(1'b1, 8, 1'b1, 24'h102, 49'h0_0000_0555, 2'd0, 40'h00_0000_0555, 3'b101, 24'd5);
    for (int a = 0; a < 4; a++) lookup({3'd6, 49'h0_0000_0555, 12'h004}, 2'(a), "R5");

    // R7: overlapping entries, lowest index wins
    wr_ent(1'b1, 10, 1'b1, 24'h103, 49'h0_0990_0000, 2'd3, 40'h00_0AAA_0000, 3'b111, 24'd5);
    wr_ent(1'b1, 12, 1'b1, 24'h103, 49'h0_0990_0123, 2'd0, 40'h00_0BBB_0000, 3'b111, 24'd5);
    lookup({3'd3, 49'h0_0990_0123, 12'h456}, 2'd0, "R7");
    lookup({3'd3, 49'h0_0990_0124, 12'h456}, 2'd0, "R7");

    // R8: victim pointer skips override writes (slot 5 next)
    wr_ent(1'b0, 0, 1'b1, 24'h100, 49'h0_0000_0ABC, 2'd0, 40'h00_0000_0ABC, 3'b111, 24'd5);
    for (int i = 0; i < 11; i++)
      wr_ent(1'b0, 0, 1'b1, 24'h101, 49'h0_00F0_0000 + 49'(i), 2'd0, 40'(i), 3'b111, 24'd5);
    lookup({3'd0, 49'h0_0000_0ABC, 12'h000}, 2'd0, "R8");
    lookup({3'd1, 49'h0_1234_5678, 12'h000}, 2'd0, "R8");
    lookup({3'd1, 49'h0_2222_0000, 12'h000}, 2'd0, "R8");

    // R9: back-pressure holds the first result
    @(negedge clk);
    res_ready = 1'b0;
    req_va = {3'd0, 49'h0_0000_0ABC, 12'h321}; req_acc = 2'd0; req_valid = 1'b1;
    @(negedge clk);
    model({3'd0, 49'h0_0000_0ABC, 12'h321}, 2'd0, epa, eh, em, ef);
    req_va = {3'd1, 49'h0_00F0_0003, 12'h005};
    for (int i = 0; i < 3; i++) begin
      chk("R9", "held res_valid", 64'(res_valid), 64'd1);
      chk("R9", "held res_pa", 64'(res_pa), 64'(epa));
      chk("R9", "req_ready stalled", 64'(req_ready), 64'd0);
      @(negedge clk);
    end
    res_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    model({3'd1, 49'h0_00F0_0003, 12'h005}, 2'd0, epa, eh, em, ef);
    chk("R9", "second res_pa", 64'(res_pa), 64'(epa));
    chk("R9", "second res_fault", 64'(res_fault), 64'(ef));
    @(negedge clk);
    chk("R9", "drained res_valid", 64'(res_valid), 64'd0);

    // random mix, R6 priority over every outcome
    for (int n = 0; n < 600; n++) begin
      int pick; int e;
      pick = int'($urandom % 10);
      if (pick == 0) wr_rgn(int'($urandom % 8), 24'h100 + 24'($urandom % 4));
      else if (pick == 1) wr_key(int'($urandom % 8), 1'($urandom % 4 != 0), 24'($urandom % 6), 3'($urandom));
      else if (pick == 2)
        wr_ent(1'($urandom), int'($urandom % 16), 1'($urandom % 5 != 0), 24'h100 + 24'($urandom % 4),
               {29'($urandom % 3), 20'($urandom)}, 2'($urandom), {8'($urandom), 32'($urandom)},
               3'($urandom), 24'($urandom % 6));
      else begin
        e = int'($urandom % 16);
        va = {3'($urandom), m_tvpn[e], 12'($urandom)};
        if ($urandom % 4 == 0) va = rnd64();
        else va = (va & ~((64'd1 << offw(m_tsz[e])) - 64'd1)) | (rnd64() & ((64'd1 << offw(m_tsz[e])) - 64'd1));
        lookup(va, 2'($urandom), "R6");
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule